// File: doc/BRIEF.md
# NAND Cached Page-Program Sequencer

This block is the host side of a raw NAND flash bus. It accepts a request holding a start row (page) address and a page count, pulls page data from a streaming source one bus unit at a time, and drives the command, address and data write cycles needed to program those pages in order. Every page except the final one is confirmed with the cache-program code. The device can then program the array while the next page is being loaded. The final page, or a lone page, is confirmed with the normal program code.

After each confirm the sequencer waits for the device's ready/busy line. It ignores that line for a guard interval first. After the last page it issues the read-status command, reads one status byte, and reports completion with an error flag taken from the pass/fail bit. If the device stays busy longer than a configured limit, the sequence is aborted. The bus width (8 or 16), page size, write-cycle length, address-to-data gap, busy guard and timeout are all parameters counted in system clocks.

Top module: `nand_cache_prog_seq`

## Requirements
- R1: After reset, `ce_n`, `we_n` and `re_n` are high, `cle`, `ale`, `io_oe` and `done` are low, and `req_ready` is high.
- R2: Each page begins with one write cycle carrying 0x80 with `cle` high and `ale` low, while `ce_n` is held low for the whole request.
- R3: The load command is followed by five write cycles with `ale` high and `cle` low. They carry, in order: 0x00, 0x00, then row bits [7:0], [15:8] and [23:16]. The row starts at `req_row` and increases by one for each further page.
- R4: At least ADL_CLKS clocks separate the rising edge of `we_n` on the last address cycle from the falling edge of `we_n` on the first data cycle.
- R5: Each page has exactly PAGE_UNITS data write cycles with `cle` and `ale` low. Each one consumes `data_in` on a one-clock `data_take` pulse and drives that unit on `io_out`.
- R6: The confirm cycle is 0x15 with `cle` high for every page except the last. It is 0x10 for the last page.
- R7: After a confirm, no new write cycle starts until `rb_n` has returned high.
- R8: After the last page completes, one write cycle carries 0x70 with `cle` high. It is followed by exactly one read cycle, in which `re_n` pulses low while `io_oe` is low.
- R9: `done` is a one-clock pulse. With it, `status` holds the byte read, `err` equals its bit 0, and `timed_out` is low.
- R10: If `rb_n` stays low for TMO_CLKS clocks after the guard interval, `done` pulses with `err` and `timed_out` high. No further bus cycles follow, and `ce_n` returns high.
- R11: In every write cycle, `we_n` is low for exactly WC_CLKS/2 clocks.
- R12: A request with a page count of zero is ignored: `ce_n` stays high, no bus cycle occurs, and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_row | input | ROW_W | First row (page) address |
| req_pages | input | PG_W | Number of pages to program |
| data_in | input | DATA_W | Next data unit of the stream |
| data_take | output | 1 | Current `data_in` is consumed this clock |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Program failed or timed out, valid with `done` |
| timed_out | output | 1 | Busy timeout occurred, valid with `done` |
| status | output | 8 | Status byte read from the device |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | DATA_W | Bus value driven by the host |
| io_oe | output | 1 | Host drives the bus |
| io_in | input | DATA_W | Bus value returned by the device |
| rb_n | input | 1 | Device ready (high) / busy (low) |

## Verification
The assertions assume three things about the inputs. The data source always has a valid unit on `data_in` when `data_take` pulses. `rb_n` is already synchronous to `clk`. The device pulls `rb_n` low within the busy guard interval after a confirm, so the guard hides the stale ready level. The bench's device model drives `rb_n` and `io_in` only on falling clock edges, and drops ready/busy on the clock after it sees the confirm strobe. Data is supplied from a counter that advances only after each `data_take`. This keeps the stimulus inside those assumptions.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   localparam logic [7:0] OP_LOAD   = 8'h80;
   localparam logic [7:0] OP_CACHE  = 8'h15;
   localparam logic [7:0] OP_FINAL  = 8'h10;
   localparam logic [7:0] OP_STATUS = 8'h70;

   localparam int ADDR_CYCLES = 5;

   typedef enum logic [3:0] {
      S_IDLE,
      S_LOAD,
      S_ADDR,
      S_ADL,
      S_DATA,
      S_CONF,
      S_WAIT,
      S_STCMD,
      S_STRD
   } seq_state_t;

   // Two zero column bytes, then the row from low byte to high byte.
   function automatic logic [7:0] addr_byte(input logic [23:0] row, input logic [2:0] idx);
      case (idx)
         3'd0, 3'd1: addr_byte = 8'h00;
         3'd2:       addr_byte = row[7:0];
         3'd3:       addr_byte = row[15:8];
         default:    addr_byte = row[23:16];
      endcase
   endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle #(
   parameter int DATA_W  = 8,
   parameter int WC_CLKS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd,
   input  logic              cle_i,
   input  logic              ale_i,
   input  logic [DATA_W-1:0] dout_i,
   output logic              busy,
   output logic              done,
   output logic [7:0]        rdata,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [DATA_W-1:0] io_out,
   output logic              io_oe,
   input  logic [DATA_W-1:0] io_in
);

   localparam int LOW = WC_CLKS / 2;
   localparam int CW  = $clog2(WC_CLKS);

   logic [CW-1:0]     cnt_q;
   logic              act_q, rd_q, cle_q, ale_q;
   logic [DATA_W-1:0] dat_q;
   logic [7:0]        rdat_q;
   logic              strobe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         act_q  <= 1'b0;
         rd_q   <= 1'b0;
         cle_q  <= 1'b0;
         ale_q  <= 1'b0;
         dat_q  <= '0;
         rdat_q <= '0;
      end else begin
         if (start && !act_q) begin
            act_q <= 1'b1;
            cnt_q <= '0;
            rd_q  <= rd;
            cle_q <= cle_i;
            ale_q <= ale_i;
            dat_q <= dout_i;
         end else if (act_q) begin
            if (cnt_q == CW'(WC_CLKS - 1)) act_q <= 1'b0;
            else                           cnt_q <= cnt_q + 1'b1;
         end
         if (act_q && rd_q && cnt_q == CW'(LOW - 1)) rdat_q <= io_in[7:0];
      end
   end

   assign strobe = act_q && (cnt_q < CW'(LOW));
   assign busy   = act_q;
   assign done   = act_q && (cnt_q == CW'(WC_CLKS - 1));
   assign rdata  = rdat_q;
   assign we_n   = !(strobe && !rd_q);
   assign re_n   = !(strobe && rd_q);
   assign cle    = act_q && cle_q;
   assign ale    = act_q && ale_q;
   assign io_out = dat_q;
   assign io_oe  = act_q && !rd_q;

   // R11: the sequencer only launches a cycle on an idle engine
   p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R11: bus value is held for the whole cycle
   p_io_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(io_out));

endmodule

// File: rtl/nand_ready_wait.sv
module nand_ready_wait #(
   parameter int WB_CLKS  = 10,
   parameter int TMO_CLKS = 70000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rb_n,
   output logic ready,
   output logic tmo
);

   localparam int LIM = (WB_CLKS > TMO_CLKS) ? WB_CLKS : TMO_CLKS;
   localparam int CW  = $clog2(LIM + 1);

   logic          guard_q, watch_q;
   logic [CW-1:0] cnt_q;
   logic          at_limit;

   assign at_limit = (cnt_q == CW'(TMO_CLKS - 1));
   assign ready    = watch_q && rb_n;
   assign tmo      = watch_q && !rb_n && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         guard_q <= 1'b0;
         watch_q <= 1'b0;
         cnt_q   <= '0;
      end else if (start) begin
         guard_q <= 1'b1;
         watch_q <= 1'b0;
         cnt_q   <= '0;
      end else if (guard_q) begin
         if (cnt_q == CW'(WB_CLKS - 1)) begin
            guard_q <= 1'b0;
            watch_q <= 1'b1;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (watch_q) begin
         if (rb_n || at_limit) watch_q <= 1'b0;
         else                  cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R7: a new wait is never started while one is running
   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!guard_q && !watch_q));

   // R10: a timeout follows a busy level already seen on the previous clock
   p_tmo_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |-> $past(!rb_n));

endmodule

// File: rtl/nand_cache_prog_seq.sv
module nand_cache_prog_seq
   import nand_seq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ROW_W      = 24,
   parameter int PG_W       = 8,
   parameter int PAGE_UNITS = 2112,
   parameter int WC_CLKS    = 5,
   parameter int ADL_CLKS   = 7,
   parameter int WB_CLKS    = 10,
   parameter int TMO_CLKS   = 70000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [PG_W-1:0]   req_pages,
   input  logic [DATA_W-1:0] data_in,
   output logic              data_take,
   output logic              done,
   output logic              err,
   output logic              timed_out,
   output logic [7:0]        status,
   output logic              cle,
   output logic              ale,
   output logic              ce_n,
   output logic              we_n,
   output logic              re_n,
   output logic [DATA_W-1:0] io_out,
   output logic              io_oe,
   input  logic [DATA_W-1:0] io_in,
   input  logic              rb_n
);

   localparam int UW  = (PAGE_UNITS > 1) ? $clog2(PAGE_UNITS) : 1;
   localparam int AW  = $clog2(ADL_CLKS + 1);

   generate
      if (!(DATA_W == 8 || DATA_W == 16)) begin : g_bad_width
         $error("DATA_W must be 8 or 16");
      end
      if (ROW_W < 1 || ROW_W > 24) begin : g_bad_row
         $error("ROW_W must be 1..24");
      end
      if (WC_CLKS < 2 || ADL_CLKS < 1 || WB_CLKS < 1 || TMO_CLKS < 2 || PAGE_UNITS < 1) begin : g_bad_timing
         $error("timing counts out of range");
      end
   endgenerate

   seq_state_t        st_q;
   logic [ROW_W-1:0]  row_q;
   logic [PG_W-1:0]   left_q;
   logic [2:0]        idx_q;
   logic [UW-1:0]     unit_q;
   logic [AW-1:0]     tick_q;
   logic [7:0]        status_q;
   logic              err_q, tmo_q, done_q;

   logic              eng_start, eng_rd, eng_cle, eng_ale, eng_busy, eng_done;
   logic [DATA_W-1:0] eng_dout;
   logic [7:0]        eng_rdata;
   logic [7:0]        ctl_byte;
   logic [DATA_W-1:0] ctl_bus;
   logic              w_start, w_ready, w_tmo;
   logic              last_page, accept;

   // byte-wide control values ride on the low lane of a wide bus
   generate
      if (DATA_W == 8) begin : g_bus8
         assign ctl_bus = ctl_byte;
      end else begin : g_bus16
         assign ctl_bus = {{(DATA_W - 8){1'b0}}, ctl_byte};
      end
   endgenerate

   assign last_page = (left_q == PG_W'(1));
   assign accept    = req_valid && (st_q == S_IDLE) && (req_pages != '0);

   always_comb begin
      eng_start = 1'b0;
      eng_rd    = 1'b0;
      eng_cle   = 1'b0;
      eng_ale   = 1'b0;
      ctl_byte  = 8'h00;
      eng_dout  = ctl_bus;
      case (st_q)
         S_LOAD:  begin eng_start = !eng_busy; eng_cle = 1'b1; ctl_byte = OP_LOAD; end
         S_ADDR:  begin eng_start = !eng_busy; eng_ale = 1'b1; ctl_byte = addr_byte(24'(row_q), idx_q); end
         S_DATA:  begin eng_start = !eng_busy; eng_dout = data_in; end
         S_CONF:  begin eng_start = !eng_busy; eng_cle = 1'b1; ctl_byte = last_page ? OP_FINAL : OP_CACHE; end
         S_STCMD: begin eng_start = !eng_busy; eng_cle = 1'b1; ctl_byte = OP_STATUS; end
         S_STRD:  begin eng_start = !eng_busy; eng_rd  = 1'b1; end
         default: ;
      endcase
   end

   assign data_take = (st_q == S_DATA) && !eng_busy;
   assign w_start   = (st_q == S_CONF) && eng_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         row_q    <= '0;
         left_q   <= '0;
         idx_q    <= '0;
         unit_q   <= '0;
         tick_q   <= '0;
         status_q <= '0;
         err_q    <= 1'b0;
         tmo_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: if (accept) begin
               row_q  <= req_row;
               left_q <= req_pages;
               err_q  <= 1'b0;
               tmo_q  <= 1'b0;
               st_q   <= S_LOAD;
            end
            S_LOAD: if (eng_done) begin
               idx_q <= '0;
               st_q  <= S_ADDR;
            end
            S_ADDR: if (eng_done) begin
               if (idx_q == 3'(ADDR_CYCLES - 1)) begin
                  tick_q <= '0;
                  st_q   <= S_ADL;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            S_ADL: begin
               if (tick_q == AW'(ADL_CLKS - 1)) begin
                  unit_q <= '0;
                  st_q   <= S_DATA;
               end else begin
                  tick_q <= tick_q + 1'b1;
               end
            end
            S_DATA: if (eng_done) begin
               if (unit_q == UW'(PAGE_UNITS - 1)) st_q <= S_CONF;
               else                              unit_q <= unit_q + 1'b1;
            end
            S_CONF: if (eng_done) st_q <= S_WAIT;
            S_WAIT: begin
               if (w_tmo) begin
                  status_q <= 8'h00;
                  err_q    <= 1'b1;
                  tmo_q    <= 1'b1;
                  done_q   <= 1'b1;
                  st_q     <= S_IDLE;
               end else if (w_ready) begin
                  if (last_page) begin
                     st_q <= S_STCMD;
                  end else begin
                     left_q <= left_q - 1'b1;
                     row_q  <= row_q + 1'b1;
                     st_q   <= S_LOAD;
                  end
               end
            end
            S_STCMD: if (eng_done) st_q <= S_STRD;
            S_STRD: if (eng_done) begin
               status_q <= eng_rdata;
               err_q    <= eng_rdata[0];
               done_q   <= 1'b1;
               st_q     <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   nand_bus_cycle #(.DATA_W(DATA_W), .WC_CLKS(WC_CLKS)) u_cycle (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (eng_start),
      .rd     (eng_rd),
      .cle_i  (eng_cle),
      .ale_i  (eng_ale),
      .dout_i (eng_dout),
      .busy   (eng_busy),
      .done   (eng_done),
      .rdata  (eng_rdata),
      .cle    (cle),
      .ale    (ale),
      .we_n   (we_n),
      .re_n   (re_n),
      .io_out (io_out),
      .io_oe  (io_oe),
      .io_in  (io_in)
   );

   nand_ready_wait #(.WB_CLKS(WB_CLKS), .TMO_CLKS(TMO_CLKS)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .start (w_start),
      .rb_n  (rb_n),
      .ready (w_ready),
      .tmo   (w_tmo)
   );

   assign req_ready = (st_q == S_IDLE);
   assign ce_n      = (st_q == S_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign timed_out = tmo_q;
   assign status    = status_q;

   // R3: command and address latches are never raised together
   p_cle_ale_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));

   // R9: completion is a single-clock pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1: with the chip deselected the bus is quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (we_n && re_n && !io_oe));

   // R5: a consumed unit becomes a host-driven data cycle
   p_take_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_take |=> (io_oe && !cle && !ale));

endmodule

// File: tb/nand_cache_prog_seq_tb.sv
module nand_cache_prog_seq_tb;

   localparam int DW    = 8;
   localparam int UNITS = 4;
   localparam int WC    = 4;
   localparam int LOW   = WC / 2;
   localparam int ADL   = 3;
   localparam int WB    = 3;
   localparam int TMO   = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_row = '0;
   logic [7:0]  req_pages = '0;
   logic [7:0]  src = 8'h30;
   logic        data_take, done, err, timed_out;
   logic [7:0]  status;
   logic        cle, ale, ce_n, we_n, re_n, io_oe;
   logic [7:0]  io_out;
   logic [7:0]  stat_byte = 8'h00;
   logic        rb_n = 1'b1;

   always #5 clk = ~clk;

   nand_cache_prog_seq #(
      .DATA_W(DW), .ROW_W(24), .PG_W(8), .PAGE_UNITS(UNITS), .WC_CLKS(WC),
      .ADL_CLKS(ADL), .WB_CLKS(WB), .TMO_CLKS(TMO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_row(req_row), .req_pages(req_pages), .data_in(src), .data_take(data_take),
      .done(done), .err(err), .timed_out(timed_out), .status(status),
      .cle(cle), .ale(ale), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
      .io_out(io_out), .io_oe(io_oe), .io_in(stat_byte), .rb_n(rb_n)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [17:0] expq[$];
   int busy_len = 10;
   int busy_cnt = 0;
   int low_run = 0;
   int gap = 0;
   int we_falls = 0;
   int re_falls = 0;
   int cycles = 0;
   bit waiting = 0;
   bit after_addr = 0;
   bit prev_we = 1;
   bit prev_re = 1;
   bit take_prev = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // device model and bus monitor, all on the falling edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (cle && ale) chk(0, "R3 cle/ale overlap", 1, 0);
         if (!we_n) low_run++;
         gap++;
         if (!prev_we && we_n) begin
            logic [1:0]  kind;
            logic [17:0] got;
            chk(low_run == LOW, "R11 we_n low width", low_run, LOW);
            low_run = 0;
            kind = cle ? 2'd0 : (ale ? 2'd1 : 2'd2);
            got = {kind, 8'h00, io_out};
            if (expq.size() == 0) begin
               chk(0, "R2 unexpected write cycle", int'(got), 0);
            end else begin
               logic [17:0] e;
               e = expq.pop_front();
               if (kind == 2'd1)      chk(got == e, "R3 address cycle", int'(got), int'(e));
               else if (kind == 2'd2) chk(got == e, "R5 data cycle", int'(got), int'(e));
               else                   chk(got == e, "R2 R6 R8 command cycle", int'(got), int'(e));
            end
            if (cle && (io_out == 8'h10 || io_out == 8'h15)) begin
               waiting = 1;
               busy_cnt = busy_len;
            end
            if (ale) begin after_addr = 1; gap = 0; end
         end
         if (prev_we && !we_n) begin
            we_falls++;
            if (waiting) chk(0, "R7 cycle while busy", 1, 0);
            if (after_addr && !cle && !ale) begin
               chk(gap >= ADL, "R4 address-to-data gap", gap, ADL);
               after_addr = 0;
            end
         end
         if (prev_re && !re_n) begin
            re_falls++;
            chk(!io_oe, "R8 bus released on read", int'(io_oe), 0);
         end
      end
      if (busy_cnt > 0) begin
         rb_n = 1'b0;
         busy_cnt--;
      end else begin
         rb_n = 1'b1;
         waiting = 0;
      end
      if (take_prev) src = src + 8'd1;
      take_prev = data_take;
      prev_we = we_n;
      prev_re = re_n;
   end

   task automatic queue_pages(input logic [23:0] row, input int pages, input int npg_run);
      logic [7:0] d;
      d = src;
      for (int p = 0; p < npg_run; p++) begin
         logic [23:0] r;
         r = row + 24'(p);
         expq.push_back({2'd0, 16'h0080});
         expq.push_back({2'd1, 16'h0000});
         expq.push_back({2'd1, 16'h0000});
         expq.push_back({2'd1, 8'h00, r[7:0]});
         expq.push_back({2'd1, 8'h00, r[15:8]});
         expq.push_back({2'd1, 8'h00, r[23:16]});
         for (int u = 0; u < UNITS; u++) begin
            expq.push_back({2'd2, 8'h00, d});
            d = d + 8'd1;
         end
         expq.push_back({2'd0, 8'h00, (p == pages - 1) ? 8'h10 : 8'h15});
      end
   endtask

   task automatic launch(input logic [23:0] row, input logic [7:0] pages);
      @(negedge clk);
      req_row = row;
      req_pages = pages;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 0;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin seen = 1; break; end
         @(negedge clk);
      end
      chk(seen, "R9 watchdog waiting for done", 0, 1);
   endtask

   task automatic run_ok(input logic [23:0] row, input int pages, input logic [7:0] st, input int busy);
      bit seen;
      int re0;
      stat_byte = st;
      busy_len = busy;
      re0 = re_falls;
      queue_pages(row, pages, pages);
      expq.push_back({2'd0, 16'h0070});
      launch(row, 8'(pages));
      chk(!ce_n, "R2 chip enabled during request", int'(ce_n), 0);
      wait_done(seen);
      if (seen) begin
         chk(status == st, "R9 status byte", int'(status), int'(st));
         chk(err == st[0], "R9 error flag", int'(err), int'(st[0]));
         chk(!timed_out, "R9 no timeout", int'(timed_out), 0);
         chk(expq.size() == 0, "R5 R6 all cycles issued", expq.size(), 0);
         chk(re_falls - re0 == 1, "R8 one read cycle", re_falls - re0, 1);
         @(negedge clk);
         chk(!done, "R9 done is one clock", int'(done), 0);
         chk(ce_n, "R9 chip released", int'(ce_n), 1);
      end
   endtask

   initial begin
      bit seen;
      int wf;
      repeat (3) @(negedge clk);
      chk(ce_n && we_n && re_n, "R1 strobes idle", {ce_n, we_n, re_n}, 3'b111);
      chk(!cle && !ale && !io_oe, "R1 latches low", {cle, ale, io_oe}, 0);
      chk(!done && req_ready, "R1 ready, not done", {done, req_ready}, 2'b01);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(ce_n && req_ready, "R1 idle after reset", {ce_n, req_ready}, 2'b11);

      // single page: normal confirm, passing status
      run_ok(24'h000123, 1, 8'hE0, 12);
      // three pages across a row byte carry, cache confirms, failing status
      run_ok(24'h00FFFF, 3, 8'hE1, 25);
      // two pages with a long busy time on each
      run_ok(24'hABCDEF, 2, 8'hC0, 60);

      // zero pages: nothing happens
      wf = we_falls;
      launch(24'h000500, 8'd0);
      repeat (20) @(negedge clk);
      chk(ce_n && req_ready, "R12 zero-page request ignored", {ce_n, req_ready}, 2'b11);
      chk(we_falls == wf, "R12 no bus cycle", we_falls - wf, 0);

      // timeout: device stays busy after the first cache confirm
      busy_len = 100000;
      queue_pages(24'h000010, 2, 1);
      launch(24'h000010, 8'd2);
      wait_done(seen);
      if (seen) begin
         chk(err && timed_out, "R10 timeout flags", {err, timed_out}, 2'b11);
         wf = we_falls;
         repeat (30) @(negedge clk);
         chk(ce_n, "R10 chip released", int'(ce_n), 1);
         chk(we_falls == wf, "R10 no cycles after timeout", we_falls - wf, 0);
         chk(expq.size() == 0, "R10 cycles before timeout", expq.size(), 0);
      end
      busy_cnt = 0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   always @(negedge clk) begin
      if (cycles > 150000) begin
         chk(0, "watchdog expired", cycles, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule